// File: doc/BRIEF.md
# Test-Under-Mask Condition Code Unit

This execution unit evaluates a family of test-under-mask operations and returns a 2-bit condition code. Each request carries an opcode (a primary byte and an extension byte), a 64-bit register operand, a byte already fetched from memory, and a 16-bit immediate. The opcode picks the variant. A memory variant tests the byte against the low eight bits of the immediate. A register variant places the 16-bit immediate at one of four halfword positions of the 64-bit register and tests the register against it.

The unit ANDs the operand with the mask at full operand width. An all-zero result gives code 0. A result equal to the mask gives code 3. Any other result is mixed, and the code is then 2 or 1, chosen by the operand bit under the mask's most significant set bit. The unit accepts one request in every cycle. The result comes out of a register one clock after the request. An encoding outside the supported set raises an illegal flag and does not change the code.

Top module: `tum_cc_unit`

## Requirements
- R1: A synchronous active-high reset drives `res_valid`, `res_cc` and `res_illegal` to 0 at the next clock edge.
- R2: `req_ready` is always 1. A request with `req_valid` high in one cycle gives `res_valid` high after exactly the next rising edge. With no request, `res_valid` is low after that edge.
- R3: If the AND of operand and mask is zero, `res_cc` is 0. This includes an all-zero mask.
- R4: If the mask is nonzero and every operand bit the mask selects is one, `res_cc` is 3.
- R5: A mixed result gives `res_cc` = 2 when the operand bit at the position of the mask's highest set bit is one, and 1 when that bit is zero.
- R6: `op_major` = 0x91 with any `op_minor`, and `op_major` = 0xEB with `op_minor` = 0x51, are memory variants. Their operand is `mem_byte` and their mask is `imm[7:0]`. `reg_val` and `imm[15:8]` have no effect on them.
- R7: `op_major` = 0xA7 selects a register variant through `op_minor[3:0]`. The values 2, 3, 0 and 1 shift the 16-bit `imm` left by 48, 32, 16 and 0 bits. The operand is `reg_val`, and `op_minor[7:4]` is ignored.
- R8: The AND and the comparison with the mask cover all 64 bits. A mask in bits 63:48 is evaluated without truncation.
- R9: Every other encoding, including 0xA7 with `op_minor[3:0]` from 4 to 15 and 0xEB with any extension other than 0x51, gives `res_valid` = 1 and `res_illegal` = 1 one cycle later, and `res_cc` keeps its previous value. A legal request gives `res_illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Unit can take a request (always 1) |
| op_major | input | 8 | Primary opcode byte |
| op_minor | input | 8 | Opcode extension byte or nibble |
| reg_val | input | 64 | Register operand |
| mem_byte | input | 8 | Memory operand byte |
| imm | input | 16 | Immediate mask |
| res_valid | output | 1 | Result valid, one cycle after a request |
| res_cc | output | 2 | Condition code |
| res_illegal | output | 1 | Unsupported encoding seen |

## Verification
The bench uses the default widths: a 64-bit operand, 16-bit halfwords and 8-bit bytes. At these widths all four halfword positions of a register variant sit inside one 64-bit word. The sweep therefore walks a single-bit mask through every one of the 64 bit positions, including bits 63 and 0, and compares each result with a reference model in the bench. A table of hand-worked vectors covers the memory variants, zero masks, fully set operands and both outcomes of the leftmost-bit test. Directed cases cover reset, the held code after illegal encodings, and a request stream with no idle cycles.

// File: rtl/tum_pkg.sv
package tum_pkg;
  typedef enum logic [1:0] {
    KIND_MEM = 2'd0,
    KIND_REG = 2'd1,
    KIND_BAD = 2'd2
  } tum_kind_e;

  localparam logic [7:0] OPC_MEM_SHORT = 8'h91;
  localparam logic [7:0] OPC_MEM_LONG  = 8'hEB;
  localparam logic [7:0] OPC_MEM_LONGX = 8'h51;
  localparam logic [7:0] OPC_REG_GROUP = 8'hA7;
endpackage

// File: rtl/tum_decode.sv
module tum_decode
  import tum_pkg::*;
(
  input  logic [7:0] op_major,
  input  logic [7:0] op_minor,
  output tum_kind_e  kind,
  output logic [1:0] hw_idx
);
  always_comb begin
    kind   = KIND_BAD;
    hw_idx = 2'd0;
    unique case (op_major)
      OPC_MEM_SHORT: kind = KIND_MEM;
      OPC_MEM_LONG: begin
        if (op_minor == OPC_MEM_LONGX) kind = KIND_MEM;
      end
      OPC_REG_GROUP: begin
        kind = KIND_REG;
        case (op_minor[3:0])
          4'h2:    hw_idx = 2'd3;
          4'h3:    hw_idx = 2'd2;
          4'h0:    hw_idx = 2'd1;
          4'h1:    hw_idx = 2'd0;
          default: kind   = KIND_BAD;
        endcase
      end
      default: kind = KIND_BAD;
    endcase
  end
endmodule

// File: rtl/tum_operand.sv
module tum_operand
  import tum_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  tum_kind_e         kind,
  input  logic [1:0]        hw_idx,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [BYTE_W-1:0] mem_byte,
  input  logic [HALF_W-1:0] imm,
  output logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] mask
);
  localparam int SHW = $clog2(DATA_W);

  logic [DATA_W-1:0] imm_wide;
  logic [SHW-1:0]    sh_amt;

  assign imm_wide = DATA_W'(imm);
  assign sh_amt   = SHW'(hw_idx) * SHW'(HALF_W);

  always_comb begin
    opnd = '0;
    mask = '0;
    case (kind)
      KIND_MEM: begin
        opnd = DATA_W'(mem_byte);
        mask = DATA_W'(imm[BYTE_W-1:0]);
      end
      KIND_REG: begin
        opnd = reg_val;
        mask = imm_wide << sh_amt;
      end
      default: begin
        opnd = '0;
        mask = '0;
      end
    endcase
  end
endmodule

// File: rtl/tum_cc_calc.sv
module tum_cc_calc #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] mask,
  output logic [1:0]        cc
);
  logic [DATA_W-1:0] sel;
  logic              lead_bit;

  assign sel = opnd & mask;

  // Operand bit under the highest set mask bit; the scan runs upward so
  // the last hit wins.
  always_comb begin
    lead_bit = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (mask[i]) lead_bit = opnd[i];
    end
  end

  always_comb begin
    if (sel == '0)       cc = 2'd0;
    else if (sel == mask) cc = 2'd3;
    else if (lead_bit)   cc = 2'd2;
    else                 cc = 2'd1;
  end
endmodule

// File: rtl/tum_cc_unit.sv
module tum_cc_unit
  import tum_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        op_major,
  input  logic [7:0]        op_minor,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [BYTE_W-1:0] mem_byte,
  input  logic [HALF_W-1:0] imm,
  output logic              res_valid,
  output logic [1:0]        res_cc,
  output logic              res_illegal
);
  tum_kind_e         kind;
  logic [1:0]        hw_idx;
  logic [DATA_W-1:0] opnd;
  logic [DATA_W-1:0] mask;
  logic [1:0]        cc_next;

  assign req_ready = 1'b1;

  tum_decode u_dec (
    .op_major (op_major),
    .op_minor (op_minor),
    .kind     (kind),
    .hw_idx   (hw_idx)
  );

  tum_operand #(.DATA_W(DATA_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_opnd (
    .kind     (kind),
    .hw_idx   (hw_idx),
    .reg_val  (reg_val),
    .mem_byte (mem_byte),
    .imm      (imm),
    .opnd     (opnd),
    .mask     (mask)
  );

  tum_cc_calc #(.DATA_W(DATA_W)) u_cc (
    .opnd (opnd),
    .mask (mask),
    .cc   (cc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_cc      <= 2'd0;
      res_illegal <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_illegal <= (kind == KIND_BAD);
        if (kind != KIND_BAD) res_cc <= cc_next;
      end
    end
  end

  // R2: result valid follows a request by one edge, and only then
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);

  // R3: zero AND result on a legal request gives code 0
  a_r3_zero_sel: assert property (@(posedge clk) disable iff (rst)
    (req_valid && kind != KIND_BAD && (opnd & mask) == '0) |=> res_cc == 2'd0);

  // R4: every selected bit set gives code 3
  a_r4_all_set: assert property (@(posedge clk) disable iff (rst)
    (req_valid && kind != KIND_BAD && mask != '0 && (opnd & mask) == mask)
      |=> res_cc == 2'd3);

  // R9: unsupported encoding raises the flag and holds the code
  a_r9_flag: assert property (@(posedge clk) disable iff (rst)
    (req_valid && kind == KIND_BAD) |=> (res_illegal && res_valid));
  a_r9_cc_held: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_illegal && !$past(rst)) |-> $stable(res_cc));
endmodule

// File: tb/tum_cc_unit_bench.sv
module tum_cc_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {op_major, op_minor, reg_val, mem_byte, imm, expected cc}
  localparam logic [105:0] VEC [NVEC] = '{
    {8'h91, 8'h00, 64'h0, 8'hF0, 16'h000F, 2'd0},                     // R3 memory
    {8'h91, 8'h37, 64'h0, 8'hFF, 16'h003C, 2'd3},                     // R4 memory
    {8'h91, 8'h00, 64'h0, 8'h80, 16'h0081, 2'd2},                     // R5 lead one
    {8'hEB, 8'h51, 64'h0, 8'h01, 16'h0081, 2'd1},                     // R5 lead zero
    {8'hA7, 8'h01, 64'h0000_0000_0000_00F0, 8'h00, 16'h00FF, 2'd2},   // R5 reg
    {8'hA7, 8'h02, 64'hFFFF_0000_0000_0000, 8'h00, 16'hFFFF, 2'd3},   // R8 top half
    {8'hA7, 8'h03, 64'h0000_0001_0000_0000, 8'h00, 16'h8001, 2'd1},   // R7 shift 32
    {8'hA7, 8'h00, 64'h0000_0000_8000_0000, 8'h00, 16'h8000, 2'd3},   // R7 shift 16
    {8'hA7, 8'h01, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 16'h0000, 2'd0},   // R3 zero mask
    {8'hA7, 8'h02, 64'h8000_0000_0000_0001, 8'h00, 16'h8000, 2'd3},   // R8 bit 63
    {8'hA7, 8'hF1, 64'h0000_0000_0000_0001, 8'h00, 16'h0001, 2'd3},   // R7 bit 0
    {8'hA7, 8'h03, 64'h0000_8000_0000_0000, 8'h00, 16'hC000, 2'd2},   // R5 shift 32
    {8'h91, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 16'hFF00, 2'd0},   // R6 ignore
    {8'hEB, 8'h51, 64'h0, 8'hFF, 16'h0000, 2'd0}                      // R3 zero mask mem
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  op_major = '0;
  logic [7:0]  op_minor = '0;
  logic [63:0] reg_val = '0;
  logic [7:0]  mem_byte = '0;
  logic [15:0] imm = '0;
  logic        res_valid;
  logic [1:0]  res_cc;
  logic        res_illegal;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  logic [1:0] last_cc = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tum_cc_unit u_tum_cc_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .op_major(op_major), .op_minor(op_minor), .reg_val(reg_val),
    .mem_byte(mem_byte), .imm(imm), .res_valid(res_valid),
    .res_cc(res_cc), .res_illegal(res_illegal)
  );

  function automatic logic [1:0] ref_cc(logic [63:0] v, logic [63:0] m);
    logic [63:0] r;
    r = v & m;
    if (r == 64'h0) return 2'd0;
    if (r == m) return 2'd3;
    for (int i = 63; i >= 0; i--)
      if (m[i]) return v[i] ? 2'd2 : 2'd1;
    return 2'd0;
  endfunction

  function automatic int shift_of(logic [3:0] sub);
    case (sub)
      4'h2: return 48;
      4'h3: return 32;
      4'h0: return 16;
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge, check the result at the next one.
  task automatic run(string req, logic [7:0] maj, logic [7:0] mnr,
                     logic [63:0] rv, logic [7:0] mb, logic [15:0] im,
                     logic [1:0] exp_cc, logic exp_ill);
    op_major = maj; op_minor = mnr; reg_val = rv; mem_byte = mb; imm = im;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 32'(res_valid), 32'd1);
    check({req, " illegal"}, 32'(res_illegal), 32'(exp_ill));
    check({req, " cc"}, 32'(res_cc), 32'(exp_ill ? last_cc : exp_cc));
    if (!exp_ill) last_cc = exp_cc;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 32'(res_valid), 32'd0);
    check("R1 cc", 32'(res_cc), 32'd0);
    check("R1 illegal", 32'(res_illegal), 32'd0);
    check("R2 ready", 32'(req_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle", 32'(res_valid), 32'd0);

    // Vector table: R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      run("R5 table", VEC[k][105:98], VEC[k][97:90], VEC[k][89:26],
          VEC[k][25:18], VEC[k][17:2], VEC[k][1:0], 1'b0);
    end

    // R8/R7 sweep: single-bit mask at each of 64 positions
    for (int sub = 0; sub < 4; sub++) begin
      for (int b = 0; b < 16; b++) begin
        logic [63:0] m;
        m = 64'(16'(1) << b) << shift_of(4'(sub));
        run("R8 sweep ones", 8'hA7, 8'(sub), '1, 8'h00, 16'(1) << b, 2'd3, 1'b0);
        run("R3 sweep clear", 8'hA7, 8'(sub), ~m, 8'h00, 16'(1) << b, 2'd0, 1'b0);
        run("R5 sweep mixed", 8'hA7, 8'(sub), m ^ (m >> 1) ^ 64'h1, 8'h00,
            16'h8001 | (16'(1) << b), ref_cc(m ^ (m >> 1) ^ 64'h1,
            64'(16'h8001 | (16'(1) << b)) << shift_of(4'(sub))), 1'b0);
      end
    end

    // R6: register value and immediate high byte have no effect
    run("R6 ignore", 8'h91, 8'hAA, 64'h0, 8'h5A, 16'hFF5A, 2'd3, 1'b0);

    // R9: unsupported encodings hold code
    run("R9 a7 sub4", 8'hA7, 8'h04, '1, 8'h00, 16'hFFFF, 2'd0, 1'b1);
    run("R9 eb52", 8'hEB, 8'h52, '0, 8'hFF, 16'h00FF, 2'd0, 1'b1);
    run("R9 other", 8'h00, 8'h00, '0, 8'hFF, 16'h00FF, 2'd0, 1'b1);
    run("R9 legal clears", 8'h91, 8'h00, '0, 8'h01, 16'h0003, 2'd1, 1'b0);

    // R2: back-to-back requests
    op_major = 8'h91; mem_byte = 8'hFF; imm = 16'h00F0; req_valid = 1'b1;
    @(negedge clk);
    check("R2 b2b first", 32'(res_cc), 32'd3);
    mem_byte = 8'h00;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 b2b second", 32'(res_cc), 32'd0);
    check("R2 b2b valid", 32'(res_valid), 32'd1);
    @(negedge clk);
    check("R2 drop", 32'(res_valid), 32'd0);

    // R1: reset after activity
    run("R4 before reset", 8'h91, 8'h00, '0, 8'hFF, 16'h00FF, 2'd3, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 re-reset cc", 32'(res_cc), 32'd0);
    check("R1 re-reset valid", 32'(res_valid), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule